// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the speed of several cooling fans by timing their tachometer signals. For each fan it counts ticks of a scaled timebase across one full revolution, which is two rising edges of the tachometer line. The result is an 8-bit count that grows as the fan slows: with the base tick set near 22.5 kHz the count equals 1.35e6 / (RPM × divisor). Software can therefore recover the speed as RPM = 1.35e6 / (count × divisor).

A 3-bit code per fan selects a power-of-two divisor that stretches the tick. Slow fans, such as those in a power supply, then still give a count inside the 8-bit range. Every new count is compared with a per-fan limit. A count above the limit, or a saturated count from a stalled fan, sets a sticky status bit. The status stays set until software strobes a status read. The interrupt line is the OR of the status bits that are enabled by their mask bits.

Top module: `fanTachMonitor`

## Requirements
- R1: For a fan whose tachometer rising edges are Q clock cycles apart, each published count equals floor(2Q / (BASE_TICK_CYCLES × divisor)). The tachometer input passes through two synchronizing flops, and only its rising edges are used.
- R2: The divisor code of fan i sits at divSel bits [3i+2:3i]. Code n selects a divisor of 2^n for n = 0 to 7, and the reset value a register would load is code 1 (divisor 2).
- R3: If 256 ticks pass after a measurement starts and the revolution has not completed, the fan publishes 255 and starts over. A stalled fan therefore reports 255 again and again.
- R4: countUpdate of a fan is a one-cycle pulse in the cycle in which its fanCount takes a new value. Between pulses, fanCount holds its value.
- R5: On each update, the fan's status bit is set when the new count is strictly greater than its 8-bit limit (bits [8i+7:8i] of limit), or when the count is 255. A count equal to the limit does not set the bit.
- R6: A status bit stays set until statusRead is high on a clock edge. That edge clears all status bits, except a bit whose set condition occurs on the same edge.
- R7: irq is high exactly when some fan has both its status bit and its intMask bit set.
- R8: The fans are measured independently. A fan's divisor, limit and tachometer affect only its own outputs.
- R9: After reset, all counts, update pulses, status bits and irq are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tachIn | input | NUM_FANS | Raw tachometer signals, one per fan |
| divSel | input | 3*NUM_FANS | Divisor code per fan (2^code) |
| limit | input | 8*NUM_FANS | Over-limit threshold per fan |
| intMask | input | NUM_FANS | Interrupt enable per fan |
| statusRead | input | 1 | Status read strobe; clears the status bits |
| fanCount | output | 8*NUM_FANS | Latest count per fan |
| countUpdate | output | NUM_FANS | One-cycle pulse per fan when a new count is published |
| intStatus | output | NUM_FANS | Sticky over-limit status per fan |
| irq | output | 1 | Masked OR of the status bits |

## Verification
The bench runs the five fans at once with different edge spacings and divisor codes. Some spacings make the revolution an exact multiple of the tick and others fall between ticks, so both an off-by-one at the closing edge and a wrong rounding show up. It changes one fan's divisor across codes 0, 1, 3 and 7 to confirm the power-of-two scaling. It uses a stalled input and a very slow input at a small divisor to exercise saturation. Limits equal to, just below and above the count separate the strict comparison from an inclusive one. The status is then read while the count is in and out of range, which shows that the bit is sticky and sets again once read.

// File: rtl/fanTachPkg.sv
package fanTachPkg;

  typedef struct packed {
    logic restart;
    logic capture;
    logic saturate;
  } tachStrobes_t;

  typedef struct packed {
    logic countTick;
    logic cntFull;
  } tachFlags_t;

  typedef enum logic {
    ST_ARM     = 1'b0,
    ST_MEASURE = 1'b1
  } tachState_t;

endpackage

// File: rtl/tachControl.sv
module tachControl
  import fanTachPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tachIn,
  input  tachFlags_t   flags,
  output tachStrobes_t strobes
);

  logic syncA, syncB, syncPrev;
  logic tachRise;
  tachState_t state, stateNext;
  logic phase, phaseNext;

  // two-flop synchronizer followed by a rising-edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= tachIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign tachRise = syncB & ~syncPrev;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    phaseNext = phase;
    if (tachRise) begin
      if (state == ST_ARM) begin
        strobes.restart = 1'b1;
        stateNext       = ST_MEASURE;
        phaseNext       = 1'b0;
      end else if (!phase) begin
        phaseNext = 1'b1;
      end else begin
        strobes.capture = 1'b1;
        strobes.restart = 1'b1;
        phaseNext       = 1'b0;
      end
    end else if (flags.countTick && flags.cntFull) begin
      strobes.saturate = 1'b1;
      strobes.restart  = 1'b1;
      stateNext        = ST_ARM;
      phaseNext        = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_ARM;
      phase <= 1'b0;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
    end
  end

endmodule

// File: rtl/tachDatapath.sv
module tachDatapath
  import fanTachPkg::*;
#(
  parameter int BASE_TICK_CYCLES = 1067,
  parameter int COUNT_W          = 8,
  parameter int DIV_W            = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  tachStrobes_t       strobes,
  input  logic [DIV_W-1:0]   divSel,
  input  logic [COUNT_W-1:0] limit,
  input  logic               statusRead,
  output tachFlags_t         flags,
  output logic [COUNT_W-1:0] fanCount,
  output logic               countUpdate,
  output logic               statusBit
);

  localparam int PRE_W    = $clog2(BASE_TICK_CYCLES + 1);
  localparam int DIVCNT_W = (2 ** DIV_W) - 1;
  localparam logic [PRE_W-1:0]   PRE_LAST = PRE_W'(BASE_TICK_CYCLES - 1);
  localparam logic [COUNT_W-1:0] CNT_MAX  = {COUNT_W{1'b1}};

  logic [PRE_W-1:0]    preCnt;
  logic [DIVCNT_W-1:0] divCnt;
  logic [DIVCNT_W-1:0] divMask;
  logic [COUNT_W-1:0]  cnt;
  logic [COUNT_W-1:0]  newCount;
  logic                baseTick, countTick, publish, overLimit;

  assign divMask   = DIVCNT_W'((32'd1 << divSel) - 32'd1);
  assign baseTick  = (preCnt == PRE_LAST);
  assign countTick = baseTick && (divCnt >= divMask);

  assign flags.countTick = countTick;
  assign flags.cntFull   = (cnt == CNT_MAX);

  // base prescaler: one tick every BASE_TICK_CYCLES clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (strobes.restart) preCnt <= '0;
    else if (baseTick)        preCnt <= '0;
    else                      preCnt <= preCnt + 1'b1;
  end

  // divisor stage: passes every 2^divSel-th base tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                divCnt <= '0;
    else if (strobes.restart) divCnt <= '0;
    else if (countTick)       divCnt <= '0;
    else if (baseTick)        divCnt <= divCnt + 1'b1;
  end

  // period counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            cnt <= '0;
    else if (strobes.restart)             cnt <= '0;
    else if (countTick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // a tick landing on the closing edge still belongs to the revolution
  always_comb begin
    if (strobes.saturate)                 newCount = CNT_MAX;
    else if (countTick && cnt != CNT_MAX) newCount = cnt + 1'b1;
    else                                  newCount = cnt;
  end

  assign publish   = strobes.capture | strobes.saturate;
  assign overLimit = (newCount > limit) || (newCount == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fanCount    <= '0;
      countUpdate <= 1'b0;
    end else begin
      countUpdate <= publish;
      if (publish) fanCount <= newCount;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     statusBit <= 1'b0;
    else if (publish && overLimit) statusBit <= 1'b1;
    else if (statusRead)           statusBit <= 1'b0;
  end

endmodule

// File: rtl/fanTachMonitor.sv
module fanTachMonitor
  import fanTachPkg::*;
#(
  parameter int NUM_FANS         = 5,
  parameter int BASE_TICK_CYCLES = 1067,
  parameter int COUNT_W          = 8,
  parameter int DIV_W            = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_FANS-1:0]         tachIn,
  input  logic [NUM_FANS*DIV_W-1:0]   divSel,
  input  logic [NUM_FANS*COUNT_W-1:0] limit,
  input  logic [NUM_FANS-1:0]         intMask,
  input  logic                        statusRead,
  output logic [NUM_FANS*COUNT_W-1:0] fanCount,
  output logic [NUM_FANS-1:0]         countUpdate,
  output logic [NUM_FANS-1:0]         intStatus,
  output logic                        irq
);

  for (genvar f = 0; f < NUM_FANS; f++) begin : genFan
    tachStrobes_t strobes;
    tachFlags_t   flags;

    tachControl u_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .tachIn  (tachIn[f]),
      .flags   (flags),
      .strobes (strobes)
    );

    tachDatapath #(
      .BASE_TICK_CYCLES (BASE_TICK_CYCLES),
      .COUNT_W          (COUNT_W),
      .DIV_W            (DIV_W)
    ) u_dp (
      .clk         (clk),
      .rstN        (rstN),
      .strobes     (strobes),
      .divSel      (divSel[f*DIV_W +: DIV_W]),
      .limit       (limit[f*COUNT_W +: COUNT_W]),
      .statusRead  (statusRead),
      .flags       (flags),
      .fanCount    (fanCount[f*COUNT_W +: COUNT_W]),
      .countUpdate (countUpdate[f]),
      .statusBit   (intStatus[f])
    );
  end

  assign irq = |(intStatus & intMask);

endmodule

// File: rtl/fanTachChecker.sv
module fanTachChecker #(
  parameter int NUM_FANS = 5,
  parameter int COUNT_W  = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        statusRead,
  input logic [NUM_FANS-1:0]         intMask,
  input logic [NUM_FANS*COUNT_W-1:0] fanCount,
  input logic [NUM_FANS-1:0]         countUpdate,
  input logic [NUM_FANS-1:0]         intStatus,
  input logic                        irq
);

  localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};

  for (genvar f = 0; f < NUM_FANS; f++) begin : genChk
    AST_UPDATE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      countUpdate[f] |=> !countUpdate[f]); // R4
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !countUpdate[f] |-> $stable(fanCount[f*COUNT_W +: COUNT_W])); // R4
    AST_SAT_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
      (countUpdate[f] && fanCount[f*COUNT_W +: COUNT_W] == CNT_MAX) |-> intStatus[f]); // R5
    AST_STATUS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(intStatus[f]) |-> countUpdate[f]); // R5
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (intStatus[f] && !statusRead) |=> intStatus[f]); // R6
    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      statusRead |=> (!intStatus[f] || countUpdate[f])); // R6
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((intStatus & intMask) == '0) |-> !irq); // R7
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    ((intStatus & intMask) != '0) |-> irq); // R7

endmodule

bind fanTachMonitor fanTachChecker #(
  .NUM_FANS (NUM_FANS),
  .COUNT_W  (COUNT_W)
) u_fanTachChecker (
  .clk         (clk),
  .rstN        (rstN),
  .statusRead  (statusRead),
  .intMask     (intMask),
  .fanCount    (fanCount),
  .countUpdate (countUpdate),
  .intStatus   (intStatus),
  .irq         (irq)
);

// File: tb/test_fanTachMonitor.sv
module test_fanTachMonitor;

  localparam int CLK_PERIOD = 10;
  localparam int NF         = 5;
  localparam int TICK       = 4;
  localparam int CW         = 8;
  localparam int DW         = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  wire  [NF-1:0]     tachIn;
  logic [NF*DW-1:0]  divSel = '0;
  logic [NF*CW-1:0]  limit = '1;
  logic [NF-1:0]     intMask = '0;
  logic              statusRead = 1'b0;
  logic [NF*CW-1:0]  fanCount;
  logic [NF-1:0]     countUpdate;
  logic [NF-1:0]     intStatus;
  logic              irq;

  int gapCyc [NF];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fanTachMonitor #(
    .NUM_FANS (NF), .BASE_TICK_CYCLES (TICK), .COUNT_W (CW), .DIV_W (DW)
  ) i_fanTachMonitor (
    .clk (clk), .rstN (rstN), .tachIn (tachIn), .divSel (divSel),
    .limit (limit), .intMask (intMask), .statusRead (statusRead),
    .fanCount (fanCount), .countUpdate (countUpdate),
    .intStatus (intStatus), .irq (irq)
  );

  // tachometer generators: rising edges gapCyc cycles apart, 0 = stalled low
  for (genvar g = 0; g < NF; g++) begin : genTach
    logic tachBit = 1'b0;
    assign tachIn[g] = tachBit;
    initial begin
      forever begin
        if (gapCyc[g] == 0) begin
          tachBit = 1'b0;
          @(negedge clk);
        end else begin
          tachBit = 1'b1;
          repeat (gapCyc[g] / 2) @(negedge clk);
          tachBit = 1'b0;
          repeat (gapCyc[g] - gapCyc[g] / 2) @(negedge clk);
        end
      end
    end
  end

  function automatic int expCount(int gap, int code);
    int v;
    if (gap == 0) return 255;
    v = (2 * gap) / (TICK << code);
    return (v > 255) ? 255 : v;
  endfunction

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic waitUpdate(int fan, int n);
    int seen = 0;
    int guard = 0;
    while (seen < n && guard < 30000) begin
      @(negedge clk);
      guard++;
      if (countUpdate[fan]) seen++;
    end
    if (seen < n) begin
      checks++;
      errors++;
      $display("FAIL R4: fan %0d actual %0d updates expected %0d", fan, seen, n);
    end
  endtask

  function automatic int cntOf(int fan);
    return int'(fanCount[fan*CW +: CW]);
  endfunction

  task automatic setDiv(int fan, int code);
    divSel[fan*DW +: DW] = DW'(code);
  endtask

  task automatic setLimit(int fan, int val);
    limit[fan*CW +: CW] = CW'(val);
  endtask

  task automatic pulseRead();
    @(negedge clk);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R9 count", int'(fanCount), 0);
    chk("R9 update", int'(countUpdate), 0);
    chk("R9 status", int'(intStatus), 0);
    chk("R9 irq", int'(irq), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 count after release", int'(fanCount), 0);
  endtask

  task automatic testBasicCounts();
    waitUpdate(0, 3);
    chk("R1 fan0 gap40 code1", cntOf(0), expCount(40, 1));
    waitUpdate(1, 3);
    chk("R1 fan1 gap123 code2", cntOf(1), expCount(123, 2));
    waitUpdate(3, 2);
    chk("R8 fan3 gap60 code2", cntOf(3), expCount(60, 2));
    waitUpdate(4, 2);
    chk("R8 fan4 gap300 code4", cntOf(4), expCount(300, 4));
    chk("R5 no status under limit", int'(intStatus[1:0]), 0);
    @(negedge clk);
    chk("R4 update lasts one cycle", int'(countUpdate[4]), 0);
  endtask

  task automatic testDivisors();
    setDiv(0, 0);
    waitUpdate(0, 3);
    chk("R2 code0", cntOf(0), expCount(40, 0));
    setDiv(0, 3);
    waitUpdate(0, 3);
    chk("R2 code3", cntOf(0), expCount(40, 3));
    chk("R8 fan1 unaffected", cntOf(1), expCount(123, 2));
    setDiv(0, 0);
    waitUpdate(0, 3);
    chk("R2 back to code0", cntOf(0), 20);
  endtask

  task automatic testStall();
    waitUpdate(2, 1);
    chk("R3 stalled count", cntOf(2), 255);
    chk("R5 saturated sets status", int'(intStatus[2]), 1);
    waitUpdate(2, 1);
    chk("R3 stalled repeats", cntOf(2), 255);
  endtask

  task automatic testLimits();
    setLimit(0, 20);
    pulseRead();
    waitUpdate(0, 2);
    chk("R5 equal limit no status", int'(intStatus[0]), 0);
    setLimit(0, 19);
    waitUpdate(0, 1);
    chk("R5 above limit sets status", int'(intStatus[0]), 1);
    intMask = 5'b00001;
    @(negedge clk);
    chk("R7 irq masked in", int'(irq), 1);
    intMask = 5'b00010;
    @(negedge clk);
    chk("R7 irq masked out", int'(irq), 0);
    intMask = '0;
    setLimit(0, 255);
    waitUpdate(0, 2);
    chk("R6 status sticky", int'(intStatus[0]), 1);
    pulseRead();
    chk("R6 read clears", int'(intStatus[0]), 0);
    waitUpdate(0, 1);
    chk("R6 stays clear in range", int'(intStatus[0]), 0);
    setLimit(0, 10);
    waitUpdate(0, 1);
    chk("R6 re-arms after read", int'(intStatus[0]), 1);
    chk("R8 fan1 status untouched", int'(intStatus[1]), 0);
    setLimit(0, 255);
    pulseRead();
  endtask

  task automatic testSlowFan();
    gapCyc[3] = 2000;
    setDiv(3, 7);
    waitUpdate(3, 3);
    chk("R2 code7 slow fan", cntOf(3), expCount(2000, 7));
    setDiv(3, 0);
    waitUpdate(3, 2);
    chk("R3 slow fan small divisor saturates", cntOf(3), 255);
  endtask

  initial begin
    gapCyc[0] = 40;
    gapCyc[1] = 123;
    gapCyc[2] = 0;
    gapCyc[3] = 60;
    gapCyc[4] = 300;
    setDiv(0, 1);
    setDiv(1, 2);
    setDiv(2, 0);
    setDiv(3, 2);
    setDiv(4, 4);
    repeat (3) @(negedge clk);
    testReset();
    testBasicCounts();
    testStall();
    testDivisors();
    testLimits();
    testSlowFan();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule